// File: doc/BRIEF.md
# Third-order sinc decimation filter for a one-bit sigma-delta stream

This block turns the one-bit output stream of a sigma-delta modulator into signed 16-bit conversion words. The modulator clock and data enter asynchronously and are resynchronised into the system clock domain. Each rising edge of the modulator clock captures one bit. A one counts as +1 and a zero as -1. The bits pass through three integrators and, once every 256 bits, through three comb differences. The full-precision sum is shifted right by 9, an arithmetic shift, and saturated to 16 bits.

A fresh word comes with a one-cycle data-ready pulse and a sticky acknowledge flag, which software clears by writing 1. A synchronous restart input zeroes the whole filter so that conversion blocks can be aligned to an external event such as a PWM period. Left alone, the filter free-runs. A watchdog on the modulator clock raises a sticky failure flag when edges stop arriving.

Top module: `sdm_sinc3_decim`

## Requirements
- R1: After reset, `dout` is 0x0000 and `dout_vld`, `dout_ack` and `bs_clk_fail` are all low.
- R2: Each published word equals a cascade of three 256-tap boxcar sums over the captured bits (one = +1, zero = -1), evaluated at the last bit of a 256-bit block, arithmetically shifted right by 9 and saturated to the 16-bit two's-complement range.
- R3: A stream of zeros long enough to fill the filter yields 0x8000.
- R4: A stream of ones long enough to fill the filter yields 0x7FFF; the unsaturated value +32768 is clamped.
- R5: `dout_vld` is a one-cycle pulse, at most one per 256 captured bits. After reset or a restart, no pulse is issued for the first two blocks; the first pulse belongs to the third block.
- R6: `dout_ack` rises together with `dout_vld` and stays high until `ack_clr` is 1 in a cycle with no new word; a new word wins over a clear in the same cycle.
- R7: A one-cycle `flt_restart` clears all filter state and the block count. The words that follow match R2 computed on a stream that starts at the restart.
- R8: `bs_clk_fail` sets once 64 system cycles pass with no modulator clock edge. It stays set until `fail_clr` is 1 while edges are arriving again, and it stays low while edges arrive within that window.
- R9: Only the level of `bs_data` at the rising edge of `bs_clk` matters; changes of `bs_data` while `bs_clk` is low do not alter any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bs_clk | input | 1 | Modulator clock, asynchronous to clk |
| bs_data | input | 1 | Modulator bitstream, valid at rising bs_clk |
| flt_restart | input | 1 | Synchronous filter restart, one clk cycle |
| ack_clr | input | 1 | Write-1 clear of the acknowledge flag |
| fail_clr | input | 1 | Write-1 clear of the clock-failure flag |
| dout | output | 16 | Latest signed conversion word |
| dout_vld | output | 1 | One-cycle pulse when dout is updated |
| dout_ack | output | 1 | Sticky new-data flag |
| bs_clk_fail | output | 1 | Sticky modulator-clock-failure flag |

## Verification
The hardest case to reach from the ports is an exact comparison across a filter restart: a restart issued while bits are still in the resynchroniser could silently drop or double-count one bit. The stimulus therefore waits for the modulator clock to settle before pulsing the restart. It then resets its own boxcar model, so that every later word, and the absence of words during the two settling blocks, is checked against a zero-history reference. Each bit is preceded by a deliberately wrong data level while the modulator clock is low, which exercises the edge-only capture on every single bit.

// File: rtl/sdm_sinc3_pkg.sv
package sdm_sinc3_pkg;

  localparam int unsigned SINC_ORDER = 3;

  // Integrator width: order * log2(OSR) bits of growth, one sign bit, one
  // extra bit so that the positive full-scale sum does not wrap.
  function automatic int unsigned acc_width(input int unsigned osr_log2);
    return SINC_ORDER * osr_log2 + 2;
  endfunction

endpackage

// File: rtl/sdm_input_sync.sv
module sdm_input_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bs_clk,
  input  logic bs_data,
  output logic bit_stb,
  output logic bit_val,
  output logic any_edge
);

  logic [STAGES-1:0] clk_sh_q, clk_sh_d;
  logic [STAGES-1:0] dat_sh_q, dat_sh_d;
  logic              clk_last_q;

  always_comb begin
    clk_sh_d = {clk_sh_q[STAGES-2:0], bs_clk};
    dat_sh_d = {dat_sh_q[STAGES-2:0], bs_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sh_q   <= '0;
      dat_sh_q   <= '0;
      clk_last_q <= 1'b0;
    end else begin
      clk_sh_q   <= clk_sh_d;
      dat_sh_q   <= dat_sh_d;
      clk_last_q <= clk_sh_q[STAGES-1];
    end
  end

  assign bit_stb  = clk_sh_q[STAGES-1] & ~clk_last_q;
  assign any_edge = clk_sh_q[STAGES-1] ^ clk_last_q;
  assign bit_val  = dat_sh_q[STAGES-1];

endmodule

// File: rtl/sdm_sinc3_core.sv
module sdm_sinc3_core
  import sdm_sinc3_pkg::*;
#(
  parameter int unsigned OSR_LOG2 = 8,
  parameter int unsigned ACC_W    = acc_width(OSR_LOG2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flt_clr,
  input  logic                    bit_stb,
  input  logic                    bit_val,
  output logic                    blk_vld,
  output logic signed [ACC_W-1:0] blk_sum
);

  localparam logic [OSR_LOG2-1:0] LAST_PHASE = {OSR_LOG2{1'b1}};

  logic signed [ACC_W-1:0] integ_q [SINC_ORDER];
  logic signed [ACC_W-1:0] integ_d [SINC_ORDER];
  logic signed [ACC_W-1:0] dly_q   [SINC_ORDER];
  logic signed [ACC_W-1:0] dly_d   [SINC_ORDER];
  logic signed [ACC_W-1:0] comb_out;
  logic [OSR_LOG2-1:0]     phase_q, phase_d;
  logic                    take_q, take_d;
  logic                    vld_q;
  logic signed [ACC_W-1:0] sum_q;

  // Integrator chain: each stage adds the freshly updated stage before it.
  always_comb begin
    logic signed [ACC_W-1:0] carry;
    carry = bit_val ? ACC_W'(1) : {ACC_W{1'b1}};
    for (int k = 0; k < SINC_ORDER; k++) begin
      integ_d[k] = integ_q[k] + carry;
      carry      = integ_d[k];
    end
  end

  // Comb chain on the decimated integrator output.
  always_comb begin
    logic signed [ACC_W-1:0] diff;
    diff = integ_q[SINC_ORDER-1];
    for (int k = 0; k < SINC_ORDER; k++) begin
      dly_d[k] = diff;
      diff     = diff - dly_q[k];
    end
    comb_out = diff;
  end

  always_comb begin
    phase_d = bit_stb ? phase_q + 1'b1 : phase_q;
    take_d  = bit_stb && (phase_q == LAST_PHASE);
  end

  generate
    for (genvar g = 0; g < SINC_ORDER; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          integ_q[g] <= '0;
          dly_q[g]   <= '0;
        end else if (flt_clr) begin
          integ_q[g] <= '0;
          dly_q[g]   <= '0;
        end else begin
          if (bit_stb) integ_q[g] <= integ_d[g];
          if (take_q)  dly_q[g]   <= dly_d[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      take_q  <= 1'b0;
      vld_q   <= 1'b0;
      sum_q   <= '0;
    end else if (flt_clr) begin
      phase_q <= '0;
      take_q  <= 1'b0;
      vld_q   <= 1'b0;
      sum_q   <= '0;
    end else begin
      phase_q <= phase_d;
      take_q  <= take_d;
      vld_q   <= take_q;
      if (take_q) sum_q <= comb_out;
    end
  end

  assign blk_vld = vld_q;
  assign blk_sum = sum_q;

endmodule

// File: rtl/sdm_out_stage.sv
module sdm_out_stage #(
  parameter int unsigned ACC_W  = 26,
  parameter int unsigned SHIFT  = 9,
  parameter int unsigned OUT_W  = 16,
  parameter int unsigned SETTLE = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flt_clr,
  input  logic                    blk_vld,
  input  logic signed [ACC_W-1:0] blk_sum,
  input  logic                    ack_clr,
  output logic [OUT_W-1:0]        dout,
  output logic                    dout_vld,
  output logic                    dout_ack
);

  localparam int unsigned SW = $clog2(SETTLE + 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic [SW-1:0]           settle_q, settle_d;
  logic                    publish;
  logic signed [ACC_W-1:0] shifted;
  logic [OUT_W-1:0]        word_d, word_q;
  logic                    vld_q;
  logic                    ack_q, ack_d;

  always_comb begin
    publish  = blk_vld && (settle_q == SW'(SETTLE - 1));
    settle_d = (blk_vld && (settle_q != SW'(SETTLE - 1))) ? settle_q + 1'b1 : settle_q;
    shifted  = blk_sum >>> SHIFT;
    if (shifted > MAXV)      word_d = MAXV[OUT_W-1:0];
    else if (shifted < MINV) word_d = MINV[OUT_W-1:0];
    else                     word_d = shifted[OUT_W-1:0];
    ack_d = publish | (ack_q & ~ack_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      word_q   <= '0;
      vld_q    <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      ack_q <= ack_d;
      if (flt_clr) begin
        settle_q <= '0;
        vld_q    <= 1'b0;
      end else begin
        settle_q <= settle_d;
        vld_q    <= publish;
        if (publish) word_q <= word_d;
      end
    end
  end

  assign dout     = word_q;
  assign dout_vld = vld_q;
  assign dout_ack = ack_q;

endmodule

// File: rtl/sdm_clk_monitor.sv
module sdm_clk_monitor #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_edge,
  input  logic fail_clr,
  output logic clk_fail
);

  localparam int unsigned CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] idle_q, idle_d;
  logic          stall;
  logic          fail_q, fail_d;

  always_comb begin
    stall = (idle_q == CW'(TIMEOUT));
    if (any_edge)   idle_d = '0;
    else if (stall) idle_d = idle_q;
    else            idle_d = idle_q + 1'b1;
    fail_d = stall | (fail_q & ~fail_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      fail_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      fail_q <= fail_d;
    end
  end

  assign clk_fail = fail_q;

endmodule

// File: rtl/sdm_sinc3_decim.sv
module sdm_sinc3_decim
  import sdm_sinc3_pkg::*;
#(
  parameter int unsigned OSR_LOG2     = 8,
  parameter int unsigned SHIFT        = 9,
  parameter int unsigned OUT_W        = 16,
  parameter int unsigned FAIL_TIMEOUT = 64,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bs_clk,
  input  logic             bs_data,
  input  logic             flt_restart,
  input  logic             ack_clr,
  input  logic             fail_clr,
  output logic [OUT_W-1:0] dout,
  output logic             dout_vld,
  output logic             dout_ack,
  output logic             bs_clk_fail
);

  localparam int unsigned ACC_W = acc_width(OSR_LOG2);

  logic                    bit_stb;
  logic                    bit_val;
  logic                    any_edge;
  logic                    blk_vld;
  logic signed [ACC_W-1:0] blk_sum;

  sdm_input_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bs_clk   (bs_clk),
    .bs_data  (bs_data),
    .bit_stb  (bit_stb),
    .bit_val  (bit_val),
    .any_edge (any_edge)
  );

  sdm_sinc3_core #(.OSR_LOG2(OSR_LOG2), .ACC_W(ACC_W)) core_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flt_clr (flt_restart),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .blk_vld (blk_vld),
    .blk_sum (blk_sum)
  );

  sdm_out_stage #(
    .ACC_W  (ACC_W),
    .SHIFT  (SHIFT),
    .OUT_W  (OUT_W),
    .SETTLE (SINC_ORDER)
  ) out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_clr  (flt_restart),
    .blk_vld  (blk_vld),
    .blk_sum  (blk_sum),
    .ack_clr  (ack_clr),
    .dout     (dout),
    .dout_vld (dout_vld),
    .dout_ack (dout_ack)
  );

  sdm_clk_monitor #(.TIMEOUT(FAIL_TIMEOUT)) mon_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .any_edge (any_edge),
    .fail_clr (fail_clr),
    .clk_fail (bs_clk_fail)
  );

endmodule

// File: rtl/sdm_sinc3_decim_chk.sv
module sdm_sinc3_decim_chk #(
  parameter int unsigned OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flt_restart,
  input logic             ack_clr,
  input logic             fail_clr,
  input logic [OUT_W-1:0] dout,
  input logic             dout_vld,
  input logic             dout_ack,
  input logic             bs_clk_fail
);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |=> !dout_vld);

  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> $stable(dout));

  a_r6_ack_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    dout_vld |-> dout_ack);

  a_r6_ack_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_ack && !ack_clr) |=> dout_ack);

  a_r6_ack_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ack_clr |=> (!dout_ack || dout_vld));

  a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flt_restart |=> !dout_vld);

  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_clk_fail && !fail_clr) |=> bs_clk_fail);

endmodule

bind sdm_sinc3_decim sdm_sinc3_decim_chk chk_i (.*);

// File: tb/sdm_sinc3_decim_tb_top.sv
module sdm_sinc3_decim_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OSR        = 256;
  localparam int SHR        = 9;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bs_clk = 1'b0;
  logic        bs_data = 1'b0;
  logic        flt_restart = 1'b0;
  logic        ack_clr = 1'b0;
  logic        fail_clr = 1'b0;
  logic [15:0] dout;
  logic        dout_vld;
  logic        dout_ack;
  logic        bs_clk_fail;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdm_sinc3_decim dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bs_clk      (bs_clk),
    .bs_data     (bs_data),
    .flt_restart (flt_restart),
    .ack_clr     (ack_clr),
    .fail_clr    (fail_clr),
    .dout        (dout),
    .dout_vld    (dout_vld),
    .dout_ack    (dout_ack),
    .bs_clk_fail (bs_clk_fail)
  );

  int    errors = 0;
  int    checks = 0;
  bit    finished = 1'b0;
  string tag = "R2";

  // Reference: three cascaded 256-long moving sums over +1/-1 bits.
  int hx [OSR];
  int g1 [OSR];
  int g2 [OSR];
  int s1, s2, s3, pos, nbits, nblk;
  int exp_q [$];
  int mon_e;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int sat16(input int v);
    int t;
    t = v >>> SHR;
    if (t > 32767)  t = 32767;
    if (t < -32768) t = -32768;
    return t & 16'hFFFF;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < OSR; i++) begin
      hx[i] = 0; g1[i] = 0; g2[i] = 0;
    end
    s1 = 0; s2 = 0; s3 = 0; pos = 0; nbits = 0; nblk = 0;
  endtask

  task automatic model_push(input bit b);
    int x;
    x  = b ? 1 : -1;
    s1 = s1 + x - hx[pos];  hx[pos] = x;
    s2 = s2 + s1 - g1[pos]; g1[pos] = s1;
    s3 = s3 + s2 - g2[pos]; g2[pos] = s2;
    pos = (pos + 1) % OSR;
    nbits++;
    if (nbits % OSR == 0) begin
      nblk++;
      if (nblk >= 3) exp_q.push_back(sat16(s3));
    end
  endtask

  // One modulator bit: wrong level while the clock is low (R9), true level
  // before the rising edge, then hold.
  task automatic send_bit(input bit b);
    @(negedge clk); bs_clk = 1'b0; bs_data = ~b;
    @(negedge clk); bs_data = b;
    @(negedge clk); bs_clk = 1'b1;
    model_push(b);
    @(negedge clk);
  endtask

  task automatic rand_block(input int nb);
    int d;
    d = $urandom_range(0, 64);
    for (int i = 0; i < nb; i++) send_bit(($urandom % 64) < d);
  endtask

  // Every data-ready pulse is compared with the oldest expected word (R2, R5).
  always @(negedge clk) begin
    if (rst_n && dout_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 data-ready without a settled block", int'(dout), 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(dout == mon_e[15:0], {tag, " word vs boxcar model (R9 glitches applied)"}, int'(dout), mon_e);
        chk(dout_ack == 1'b1, "R6 ack with new word", int'(dout_ack), 1);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd90417));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == 16'h0000, "R1 dout after reset", int'(dout), 0);
    chk(!dout_vld && !dout_ack, "R1 flags after reset", {dout_vld, dout_ack}, 0);
    chk(!bs_clk_fail, "R1 clock fail after reset", int'(bs_clk_fail), 0);

    // R3: constant low stream
    tag = "R3";
    for (int i = 0; i < 5 * OSR; i++) send_bit(1'b0);
    repeat (10) @(negedge clk);
    chk(dout == 16'h8000, "R3 all-zero stream", int'(dout), 16'h8000);

    // R4: constant high stream, saturation
    tag = "R4";
    for (int i = 0; i < 6 * OSR; i++) send_bit(1'b1);
    repeat (10) @(negedge clk);
    chk(dout == 16'h7FFF, "R4 all-one stream saturates", int'(dout), 16'h7FFF);

    // R2: random densities
    tag = "R2";
    for (int b = 0; b < 16; b++) rand_block(OSR);

    // R6: acknowledge flag behaviour
    tag = "R6";
    rand_block(10);
    chk(dout_ack == 1'b1, "R6 ack still set", int'(dout_ack), 1);
    @(negedge clk); ack_clr = 1'b1;
    @(negedge clk); ack_clr = 1'b0;
    rand_block(100);
    chk(dout_ack == 1'b0, "R6 ack stays clear without new word", int'(dout_ack), 0);
    rand_block(OSR - 110);
    repeat (10) @(negedge clk);
    chk(dout_ack == 1'b1, "R6 ack set by next word", int'(dout_ack), 1);

    // R7: restart mid-block, then periodic pattern
    rand_block(37);
    repeat (4) @(negedge clk);
    flt_restart = 1'b1;
    @(negedge clk); flt_restart = 1'b0;
    model_reset();
    tag = "R7";
    for (int i = 0; i < 6 * OSR; i++) send_bit((i % 3) == 0);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 words after restart all seen", exp_q.size(), 0);

    // R8: modulator clock stall
    tag = "R8";
    rand_block(20);
    repeat (30) @(negedge clk);
    chk(!bs_clk_fail, "R8 no failure before timeout", int'(bs_clk_fail), 0);
    repeat (60) @(negedge clk);
    chk(bs_clk_fail, "R8 failure after stall", int'(bs_clk_fail), 1);
    fail_clr = 1'b1;
    @(negedge clk); fail_clr = 1'b0;
    @(negedge clk);
    chk(bs_clk_fail, "R8 flag persists while stalled", int'(bs_clk_fail), 1);
    rand_block(4);
    @(negedge clk); fail_clr = 1'b1;
    @(negedge clk); fail_clr = 1'b0;
    rand_block(40);
    chk(!bs_clk_fail, "R8 clear sticks with running clock", int'(bs_clk_fail), 0);
    rand_block(OSR - 64);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 every settled block delivered once", exp_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule